// File: doc/BRIEF.md
# Reversible-Primitive Arithmetic-Logic Unit

A combinational N-bit arithmetic-logic unit in which every gate is modelled as a reversible primitive. The three primitives are a two-line controlled inverter, a three-line Peres gate and a three-line controlled swap. Each bit holds a ripple-carry full adder made of two cascaded Peres gates. Each bit also holds two small conditioning elements. The B-side element turns the B operand bit into the adder's second input. The A-side element turns the A operand bit into the adder's first input.

A mode select picks the operating mode. In arithmetic mode the carry chain is live. The B operand is passed through, complemented, forced to all zeros or forced to all ones, and the carry-in is added. In logic mode every carry into a bit is gated to zero. The two conditioned operands are then chosen so that the plain sum bit equals the wanted Boolean function.

Constant ancilla inputs are tied inside the block. Every line that the computation does not need is collected on a garbage bus, which carries 13 bits per data bit plus 2 for the final carry gate. No state is held, so results follow the inputs directly.

Top module: `peres_alu`

## Requirements
- R1: With modeSel=0 and funcSel=2'b01, {carryOut,result} equals opA + opB + carryIn, computed at WIDTH+1 bits.
- R2: With modeSel=0 and funcSel=2'b10, {carryOut,result} equals opA + ~opB + carryIn. With carryIn=1 the result is opA−opB in two's complement, and carryOut=1 exactly when opA ≥ opB.
- R3: With modeSel=0 and funcSel=2'b00, {carryOut,result} equals opA + carryIn. With carryIn=0 this is a transfer of opA; with carryIn=1 it is an increment.
- R4: With modeSel=0 and funcSel=2'b11, {carryOut,result} equals opA + all-ones + carryIn. With carryIn=0 this is a decrement and carryOut=1 exactly when opA≠0; with carryIn=1 it is a transfer of opA with carryOut=1.
- R5: With modeSel=1 and funcSel=2'b00, result equals opA OR opB.
- R6: With modeSel=1 and funcSel=2'b01, result equals opA XOR opB.
- R7: With modeSel=1 and funcSel=2'b10, result equals opA AND opB.
- R8: With modeSel=1 and funcSel=2'b11, result equals NOT opA, whatever opB is.
- R9: With modeSel=1, carryOut is 0 and carryIn has no effect on result.
- R10: A carry ripples across all WIDTH bits. With opA all ones, opB=1 and carryIn=0 in the R1 mode, the result is 0 and carryOut is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| modeSel | input | 1 | 0 selects arithmetic mode, 1 selects logic mode |
| funcSel | input | 2 | Function code within the selected mode |
| carryIn | input | 1 | Carry into bit 0 (arithmetic mode only) |
| result | output | WIDTH | Result word |
| carryOut | output | 1 | Carry out of the top bit; 0 in logic mode |
| garbageBus | output | WIDTH*13+2 | Unused primitive output lines, for observation only |

## Verification
The bench builds two copies of the block. The first uses WIDTH=4, which is small enough to apply every operand pair under all eight select codes and both carry-in values. That run covers every carry pattern and every boundary value. The second uses WIDTH=8 with random operands over all select and carry-in codes, plus directed vectors for full-length carry ripple, equal-operand subtraction and decrement of zero. Expected values come from a behavioural model written from the requirements.

// File: rtl/peres_alu_pkg.sv
package peres_alu_pkg;

  // Strobes that the control decoder hands to every bit slice.
  typedef struct packed {
    logic chainEn;     // let carries propagate (arithmetic mode)
    logic yInvert;     // complement B before the force stage
    logic yForce;      // replace Y by a constant
    logic yForceVal;   // constant used when yForce is set
    logic xInvert;     // complement A on the A side
    logic maskEn;      // AND the A-side value with a B-derived mask
    logic maskInvert;  // complement B to form the mask
  } ctrlStrobes_t;

  // Garbage lines produced by each part of a bit slice.
  localparam int ADDER_GARBAGE = 2;
  localparam int BSIDE_GARBAGE = 3;
  localparam int ASIDE_GARBAGE = 6;
  localparam int CGATE_GARBAGE = 2;
  localparam int BIT_GARBAGE   = ADDER_GARBAGE + BSIDE_GARBAGE
                               + ASIDE_GARBAGE + CGATE_GARBAGE;
  localparam int TAIL_GARBAGE  = CGATE_GARBAGE;

endpackage

// File: rtl/peres_alu_gates.sv
// Reversible primitives.

module rev_feynman (
  input  logic inA,
  input  logic inB,
  output logic outP,
  output logic outQ
);
  assign outP = inA;
  assign outQ = inA ^ inB;
endmodule

module rev_peres (
  input  logic inA,
  input  logic inB,
  input  logic inC,
  output logic outP,
  output logic outQ,
  output logic outR
);
  assign outP = inA;
  assign outQ = inA ^ inB;
  assign outR = (inA & inB) ^ inC;
endmodule

module rev_fredkin (
  input  logic inA,
  input  logic inB,
  input  logic inC,
  output logic outP,
  output logic outQ,
  output logic outR
);
  assign outP = inA;
  assign outQ = (~inA & inB) | (inA & inC);
  assign outR = (inA & inB) | (~inA & inC);
endmodule

// File: rtl/peres_alu_slice.sv
// Bit-slice building blocks made only of reversible primitives.

// Full adder: two cascaded Peres gates, one zero ancilla, two garbage lines.
module peres_full_adder (
  input  logic       xIn,
  input  logic       yIn,
  input  logic       cIn,
  output logic       sumOut,
  output logic       cOut,
  output logic [1:0] garbage
);
  logic halfSum;
  logic halfCarry;

  rev_peres u_stage1 (
    .inA(xIn), .inB(yIn), .inC(1'b0),
    .outP(garbage[0]), .outQ(halfSum), .outR(halfCarry)
  );

  rev_peres u_stage2 (
    .inA(halfSum), .inB(cIn), .inC(halfCarry),
    .outP(garbage[1]), .outQ(sumOut), .outR(cOut)
  );
endmodule

// B side: optional complement, then optional force to a constant.
module bside_element (
  input  logic       bIn,
  input  logic       yInvert,
  input  logic       yForce,
  input  logic       yForceVal,
  output logic       yOut,
  output logic [2:0] garbage
);
  logic bCond;

  rev_feynman u_inv (
    .inA(yInvert), .inB(bIn),
    .outP(garbage[0]), .outQ(bCond)
  );

  // Controlled swap: output Q takes yForceVal when yForce is set.
  rev_fredkin u_force (
    .inA(yForce), .inB(bCond), .inC(yForceVal),
    .outP(garbage[1]), .outQ(yOut), .outR(garbage[2])
  );
endmodule

// A side: X = (A ^ xInvert) & (maskEn ? (B ^ maskInvert) : 1).
module aside_element (
  input  logic       aIn,
  input  logic       bIn,
  input  logic       xInvert,
  input  logic       maskEn,
  input  logic       maskInvert,
  output logic       xOut,
  output logic [5:0] garbage
);
  logic aCond;
  logic bMask;
  logic maskSel;

  rev_feynman u_ainv (
    .inA(xInvert), .inB(aIn),
    .outP(garbage[0]), .outQ(aCond)
  );

  rev_feynman u_binv (
    .inA(maskInvert), .inB(bIn),
    .outP(garbage[1]), .outQ(bMask)
  );

  // Ancilla tied to 1: passes 1 through when masking is disabled.
  rev_fredkin u_masksel (
    .inA(maskEn), .inB(1'b1), .inC(bMask),
    .outP(garbage[2]), .outQ(maskSel), .outR(garbage[3])
  );

  // Ancilla tied to 0: output R is the AND of the two lines.
  rev_peres u_and (
    .inA(aCond), .inB(maskSel), .inC(1'b0),
    .outP(garbage[4]), .outQ(garbage[5]), .outR(xOut)
  );
endmodule

// Carry gate: Peres with zero ancilla, R = enable & carry.
module carry_gate (
  input  logic       enable,
  input  logic       carryRaw,
  output logic       carryGated,
  output logic [1:0] garbage
);
  rev_peres u_gate (
    .inA(enable), .inB(carryRaw), .inC(1'b0),
    .outP(garbage[0]), .outQ(garbage[1]), .outR(carryGated)
  );
endmodule

// File: rtl/peres_alu_control.sv
module peres_alu_control
  import peres_alu_pkg::*;
(
  input  logic         modeSel,
  input  logic [1:0]   funcSel,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    if (!modeSel) begin
      strobes.chainEn = 1'b1;
      unique case (funcSel)
        2'b00: begin strobes.yForce = 1'b1; strobes.yForceVal = 1'b0; end
        2'b01: ;
        2'b10: strobes.yInvert = 1'b1;
        2'b11: begin strobes.yForce = 1'b1; strobes.yForceVal = 1'b1; end
        default: ;
      endcase
    end else begin
      // Carries are gated off; X and Y chosen so X ^ Y is the function.
      unique case (funcSel)
        2'b00: begin strobes.maskEn = 1'b1; strobes.maskInvert = 1'b1; end
        2'b01: ;
        2'b10: begin strobes.xInvert = 1'b1; strobes.maskEn = 1'b1; end
        2'b11: begin
          strobes.xInvert   = 1'b1;
          strobes.yForce    = 1'b1;
          strobes.yForceVal = 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/peres_alu_datapath.sv
module peres_alu_datapath
  import peres_alu_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int GBUS_W = WIDTH * BIT_GARBAGE + TAIL_GARBAGE
) (
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic              carryIn,
  input  ctrlStrobes_t      strobes,
  output logic [WIDTH-1:0]  result,
  output logic              carryOut,
  output logic [GBUS_W-1:0] garbageBus
);
  localparam int OFS_ADD = 0;
  localparam int OFS_B   = OFS_ADD + ADDER_GARBAGE;
  localparam int OFS_A   = OFS_B + BSIDE_GARBAGE;
  localparam int OFS_C   = OFS_A + ASIDE_GARBAGE;

  logic [WIDTH:0] carryChain;
  assign carryChain[0] = carryIn;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic xBit;
    logic yBit;
    logic cinGated;

    bside_element u_bside (
      .bIn(opB[i]),
      .yInvert(strobes.yInvert),
      .yForce(strobes.yForce),
      .yForceVal(strobes.yForceVal),
      .yOut(yBit),
      .garbage(garbageBus[i*BIT_GARBAGE+OFS_B +: BSIDE_GARBAGE])
    );

    aside_element u_aside (
      .aIn(opA[i]),
      .bIn(opB[i]),
      .xInvert(strobes.xInvert),
      .maskEn(strobes.maskEn),
      .maskInvert(strobes.maskInvert),
      .xOut(xBit),
      .garbage(garbageBus[i*BIT_GARBAGE+OFS_A +: ASIDE_GARBAGE])
    );

    carry_gate u_cgate (
      .enable(strobes.chainEn),
      .carryRaw(carryChain[i]),
      .carryGated(cinGated),
      .garbage(garbageBus[i*BIT_GARBAGE+OFS_C +: CGATE_GARBAGE])
    );

    peres_full_adder u_fa (
      .xIn(xBit),
      .yIn(yBit),
      .cIn(cinGated),
      .sumOut(result[i]),
      .cOut(carryChain[i+1]),
      .garbage(garbageBus[i*BIT_GARBAGE+OFS_ADD +: ADDER_GARBAGE])
    );
  end

  carry_gate u_tailgate (
    .enable(strobes.chainEn),
    .carryRaw(carryChain[WIDTH]),
    .carryGated(carryOut),
    .garbage(garbageBus[WIDTH*BIT_GARBAGE +: TAIL_GARBAGE])
  );
endmodule

// File: rtl/peres_alu.sv
module peres_alu
  import peres_alu_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int GBUS_W = WIDTH * BIT_GARBAGE + TAIL_GARBAGE
) (
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic              modeSel,
  input  logic [1:0]        funcSel,
  input  logic              carryIn,
  output logic [WIDTH-1:0]  result,
  output logic              carryOut,
  output logic [GBUS_W-1:0] garbageBus
);
  ctrlStrobes_t strobes;

  peres_alu_control u_ctrl (
    .modeSel(modeSel),
    .funcSel(funcSel),
    .strobes(strobes)
  );

  peres_alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .opA(opA),
    .opB(opB),
    .carryIn(carryIn),
    .strobes(strobes),
    .result(result),
    .carryOut(carryOut),
    .garbageBus(garbageBus)
  );
endmodule

// File: rtl/peres_alu_checker.sv
module peres_alu_checker #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic             modeSel,
  input logic [1:0]       funcSel,
  input logic             carryIn,
  input logic [WIDTH-1:0] result,
  input logic             carryOut
);
  logic [WIDTH:0] wideA, wideB, wideNotB, wideOnes, wideCin;

  always_comb begin
    wideA    = {1'b0, opA};
    wideB    = {1'b0, opB};
    wideNotB = {1'b0, ~opB};
    wideOnes = {1'b0, {WIDTH{1'b1}}};
    wideCin  = {{WIDTH{1'b0}}, carryIn};

    if (!modeSel && funcSel == 2'b01)
      assert_add_R1: assert ({carryOut, result} == wideA + wideB + wideCin)
        else $error("add mismatch");
    if (!modeSel && funcSel == 2'b10)
      assert_sub_R2: assert ({carryOut, result} == wideA + wideNotB + wideCin)
        else $error("complement-add mismatch");
    if (!modeSel && funcSel == 2'b00)
      assert_inc_R3: assert ({carryOut, result} == wideA + wideCin)
        else $error("transfer/increment mismatch");
    if (!modeSel && funcSel == 2'b11)
      assert_dec_R4: assert ({carryOut, result} == wideA + wideOnes + wideCin)
        else $error("decrement mismatch");
    if (modeSel && funcSel == 2'b00)
      assert_or_R5: assert (result == (opA | opB)) else $error("or mismatch");
    if (modeSel && funcSel == 2'b01)
      assert_xor_R6: assert (result == (opA ^ opB)) else $error("xor mismatch");
    if (modeSel && funcSel == 2'b10)
      assert_and_R7: assert (result == (opA & opB)) else $error("and mismatch");
    if (modeSel && funcSel == 2'b11)
      assert_not_R8: assert (result == ~opA) else $error("not mismatch");
    if (modeSel)
      assert_no_carry_R9: assert (!carryOut) else $error("carry in logic mode");
  end
endmodule

bind peres_alu peres_alu_checker #(.WIDTH(WIDTH)) u_checker (
  .opA(opA),
  .opB(opB),
  .modeSel(modeSel),
  .funcSel(funcSel),
  .carryIn(carryIn),
  .result(result),
  .carryOut(carryOut)
);

// File: tb/peres_alu_bench.sv
`timescale 1ns/1ps
module peres_alu_bench;
  localparam int WIDE   = 8;
  localparam int NARROW = 4;
  localparam int GW_WIDE   = WIDE * 13 + 2;
  localparam int GW_NARROW = NARROW * 13 + 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  // Wide (8-bit) instance
  logic [WIDE-1:0]    wA, wB, wRes;
  logic               wMode, wCin, wCout;
  logic [1:0]         wFunc;
  logic [GW_WIDE-1:0] wGarb;

  // Narrow (4-bit) instance
  logic [NARROW-1:0]    nA, nB, nRes;
  logic                 nMode, nCin, nCout;
  logic [1:0]           nFunc;
  logic [GW_NARROW-1:0] nGarb;

  peres_alu #(.WIDTH(WIDE)) u_peres_alu (
    .opA(wA), .opB(wB), .modeSel(wMode), .funcSel(wFunc), .carryIn(wCin),
    .result(wRes), .carryOut(wCout), .garbageBus(wGarb)
  );

  peres_alu #(.WIDTH(NARROW)) u_peres_alu_narrow (
    .opA(nA), .opB(nB), .modeSel(nMode), .funcSel(nFunc), .carryIn(nCin),
    .result(nRes), .carryOut(nCout), .garbageBus(nGarb)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Scoreboard queues: {carry, result} and requirement tag.
  logic [8:0] expWideQ[$];
  string      tagWideQ[$];
  logic [8:0] expNarQ[$];
  string      tagNarQ[$];

  function automatic logic [8:0] refModel(input int w, input logic [7:0] a,
      input logic [7:0] b, input logic m, input logic [1:0] f, input logic c);
    int mask, av, bv, yv, sum;
    mask = (1 << w) - 1;
    av = int'(a) & mask;
    bv = int'(b) & mask;
    if (!m) begin
      case (f)
        2'b00: yv = 0;
        2'b01: yv = bv;
        2'b10: yv = (~bv) & mask;
        default: yv = mask;
      endcase
      sum = av + yv + int'(c);
      return {((sum >> w) & 1) != 0, 8'(sum & mask)};
    end
    case (f)
      2'b00: sum = av | bv;
      2'b01: sum = av ^ bv;
      2'b10: sum = av & bv;
      default: sum = (~av) & mask;
    endcase
    return {1'b0, 8'(sum)};
  endfunction

  function automatic string reqTag(input logic m, input logic [1:0] f);
    if (!m) begin
      case (f)
        2'b01: return "R1";
        2'b10: return "R2";
        2'b00: return "R3";
        default: return "R4";
      endcase
    end
    case (f)
      2'b00: return "R5 R9";
      2'b01: return "R6 R9";
      2'b10: return "R7 R9";
      default: return "R8 R9";
    endcase
  endfunction

  task automatic driveWide(input logic [7:0] a, input logic [7:0] b,
      input logic m, input logic [1:0] f, input logic c, input string tag);
    @(posedge clk);
    #1;
    wA = a; wB = b; wMode = m; wFunc = f; wCin = c;
    expWideQ.push_back(refModel(WIDE, a, b, m, f, c));
    tagWideQ.push_back(tag);
  endtask

  task automatic driveNarrow(input logic [3:0] a, input logic [3:0] b,
      input logic m, input logic [1:0] f, input logic c);
    @(posedge clk);
    #1;
    nA = a; nB = b; nMode = m; nFunc = f; nCin = c;
    expNarQ.push_back(refModel(NARROW, {4'h0, a}, {4'h0, b}, m, f, c));
    tagNarQ.push_back(reqTag(m, f));
  endtask

  // Monitor: compares away from the active edge.
  always @(negedge clk) begin
    if (expWideQ.size() > 0) begin
      logic [8:0] e;
      string t;
      e = expWideQ.pop_front();
      t = tagWideQ.pop_front();
      checks++;
      if ({wCout, wRes} !== e) begin
        fails++;
        $display("FAIL %s width8: got cout=%0b res=%02h expected cout=%0b res=%02h",
                 t, wCout, wRes, e[8], e[7:0]);
      end
    end
    if (expNarQ.size() > 0) begin
      logic [8:0] e;
      string t;
      e = expNarQ.pop_front();
      t = tagNarQ.pop_front();
      checks++;
      if ({nCout, nRes} !== {e[8], e[3:0]}) begin
        fails++;
        $display("FAIL %s width4: got cout=%0b res=%01h expected cout=%0b res=%01h",
                 t, nCout, nRes, e[8], e[3:0]);
      end
    end
  end

  initial begin
    wA = '0; wB = '0; wMode = 1'b0; wFunc = 2'b00; wCin = 1'b0;
    nA = '0; nB = '0; nMode = 1'b0; nFunc = 2'b00; nCin = 1'b0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // Idle state after reset: all-zero inputs give zero (R3 transfer).
    driveWide(8'h00, 8'h00, 1'b0, 2'b00, 1'b0, "R3 idle");

    // Directed corners on the wide instance.
    driveWide(8'hFF, 8'h01, 1'b0, 2'b01, 1'b0, "R10 R1 ripple");
    driveWide(8'h7F, 8'h80, 1'b0, 2'b01, 1'b1, "R10 R1 ripple cin");
    driveWide(8'h5A, 8'h5A, 1'b0, 2'b10, 1'b1, "R2 equal subtract");
    driveWide(8'h10, 8'h11, 1'b0, 2'b10, 1'b1, "R2 borrow");
    driveWide(8'hFF, 8'h00, 1'b0, 2'b00, 1'b1, "R3 increment wrap");
    driveWide(8'h00, 8'h33, 1'b0, 2'b11, 1'b0, "R4 decrement zero");
    driveWide(8'h80, 8'h33, 1'b0, 2'b11, 1'b0, "R4 decrement");
    driveWide(8'hC3, 8'h00, 1'b0, 2'b11, 1'b1, "R4 transfer");
    driveWide(8'hF0, 8'h0F, 1'b1, 2'b00, 1'b1, "R5 R9 or");
    driveWide(8'hF0, 8'hFF, 1'b1, 2'b01, 1'b1, "R6 R9 xor");
    driveWide(8'hFF, 8'hFF, 1'b1, 2'b10, 1'b1, "R7 R9 and");
    driveWide(8'h3C, 8'hA5, 1'b1, 2'b11, 1'b0, "R8 not b=A5");
    driveWide(8'h3C, 8'h5A, 1'b1, 2'b11, 1'b1, "R8 R9 not b=5A");

    // Exhaustive narrow run: every operand pair, code and carry-in.
    for (int m = 0; m < 2; m++)
      for (int f = 0; f < 4; f++)
        for (int c = 0; c < 2; c++)
          for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
              driveNarrow(4'(a), 4'(b), 1'(m), 2'(f), 1'(c));

    // Random wide run over all codes.
    for (int k = 0; k < 2000; k++) begin
      logic [7:0] ra, rb;
      logic [1:0] rf;
      logic rm, rc;
      ra = 8'($urandom); rb = 8'($urandom);
      rm = 1'($urandom); rf = 2'($urandom); rc = 1'($urandom);
      driveWide(ra, rb, rm, rf, rc, reqTag(rm, rf));
    end

    @(posedge clk);
    while (expWideQ.size() > 0 || expNarQ.size() > 0) @(posedge clk);
    @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule